// File: doc/BRIEF.md
# Overlay Window Command Sequencer

This block is a host-side engine that carries a single command to a phase-change memory. The memory exposes its command registers only through a memory-mapped overlay window, so the block opens that window through two mode-register writes, writes the command arguments as 16-bit halves, starts execution, polls the status register until the part reports ready, and then closes the window again. For the two buffered commands it also reads the device's program-buffer pointer. It then copies the requested number of bytes from a small local byte FIFO into consecutive words starting at that pointer.

The caller loads the FIFO if needed. It presents a command code, a 32-bit data word, a 32-bit target address and a 32-bit count, and pulses `start`. The block raises `busy` and drives a word-addressed request/acknowledge bus. It ends with a one-cycle `done` pulse, with `err` set if the ready bit never appeared within the programmed number of status polls. A strap input selects the stacked dual-x16 arrangement, in which every window register sits at four times its word offset and each control write is mirrored two words higher.

Top module: `ovw_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `err`, `mem_req` and `fifo_full` are 0.
- R2: Each command begins with two writes in mode space (`mem_space`=1): address 0x50 receives 0x0000_8018 (0x8000_0018 when `stacked`=1), then address 0x40 receives 0x01.
- R3: Next come window writes (`mem_space`=0), each carrying a zero-extended 16-bit value. They go in this order: code to 0x40, data bits 15:0 to 0x42, address bits 15:0 to 0x44, address bits 31:16 to 0x45, count bits 15:0 to 0x48, count bits 31:16 to 0x49.
- R4: When `stacked`=1 every window offset is multiplied by 4. The six control writes are followed by the same six at the scaled offset plus 2, with the data entry carrying bits 31:16. Execute is also mirrored at +2. Each status poll reads the scaled offset and then the scaled offset plus 2.
- R5: For codes 0xE9 (buffered program) and 0xEA (buffered overwrite), a read of offset 0x08 follows the control writes. Then `cmd_count` writes follow, in FIFO order, each placing one byte zero-extended at address pointer+i, where the pointer is the low address bits of that read's data.
- R6: For every other code (0x20 erase, 0x41 word program, 0x42 word overwrite, 0x61 lock, 0x62 unlock) no pointer read and no fill write occurs.
- R7: Execution starts with a write of 0x0001 to offset 0x60.
- R8: After execution the block reads status at offset 0x66 until bit 7 is 1. When `stacked`=1 it stops only when bit 7 of both halves is 1 (bits 7 and 23 of the combined word).
- R9: If `poll_limit` rounds pass without ready (a limit of 0 acts as 1), polling stops and `err` is 1 with `done`.
- R10: The window closes with the same two mode writes as R2 except that 0x02 goes to 0x40. `done` pulses for one cycle in the cycle after the last close write is acknowledged.
- R11: A `start` pulse while `busy` is 1 is ignored: the bus sequence of the running command is unchanged and no second command follows.
- R12: Once `mem_req` is raised, it and `mem_we`, `mem_space`, `mem_addr` and `mem_wdata` hold steady until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one command (ignored while busy) |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 32 | Command data word |
| cmd_addr | input | 32 | Target address |
| cmd_count | input | 32 | Count parameter / buffered byte count |
| stacked | input | 1 | 1 = dual-x16 stacked arrangement |
| poll_limit | input | 16 | Maximum status poll rounds |
| fifo_push | input | 1 | Push one byte into the local FIFO |
| fifo_byte | input | 8 | Byte to push |
| fifo_full | output | 1 | FIFO cannot accept a byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout flag, valid with done |
| mem_req | output | 1 | Bus request |
| mem_space | output | 1 | 1 = mode register space, 0 = window |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Bus acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions take for granted that the bus partner acknowledges each request with a single-cycle `mem_ack` and never acknowledges when no request is raised. They also assume that the FIFO holds at least `cmd_count` bytes before a buffered command starts and is never pushed while full. The stimulus keeps to this by using a responder that raises `mem_ack` one cycle after each new request. Bytes are pushed before each buffered command, and only a few bytes at a time, well below the FIFO depth. Status replies set extra high bits so that only bit 7 of each half can decide readiness.

// File: rtl/ovw_pkg.sv
// Shared types and constants for the overlay window command sequencer.
// Assumes word-granular window offsets; scaling for stacked parts happens elsewhere.
package ovw_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPEN,
        PH_CTRL,
        PH_PTR,
        PH_FILL,
        PH_EXEC,
        PH_POLL,
        PH_CLOSE,
        PH_DONE
    } phase_t;

    // mode register space addresses
    localparam logic [7:0] MR_CFG_ADR  = 8'h50;
    localparam logic [7:0] MR_DATA_ADR = 8'h40;

    // window word offsets
    localparam logic [7:0] OF_CODE = 8'h40;
    localparam logic [7:0] OF_DATA = 8'h42;
    localparam logic [7:0] OF_ALO  = 8'h44;
    localparam logic [7:0] OF_AHI  = 8'h45;
    localparam logic [7:0] OF_CLO  = 8'h48;
    localparam logic [7:0] OF_CHI  = 8'h49;
    localparam logic [7:0] OF_EXEC = 8'h60;
    localparam logic [7:0] OF_STAT = 8'h66;
    localparam logic [7:0] OF_PTR  = 8'h08;

    localparam logic [7:0] CODE_BUF_PROG = 8'hE9;
    localparam logic [7:0] CODE_BUF_OVR  = 8'hEA;

    // true for the two codes that copy FIFO bytes into the program buffer
    function automatic logic is_buffered(input logic [7:0] code);
        return (code == CODE_BUF_PROG) || (code == CODE_BUF_OVR);
    endfunction

endpackage

// File: rtl/ovw_byte_fifo.sv
// Small byte FIFO feeding the program-buffer fill.
// Assumes the producer never pushes while full and the consumer never pops while empty.
module ovw_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
        end
    end

    assign head  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == (PW+1)'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (PW+1)'(DEPTH)); // R5
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5
endmodule

// File: rtl/ovw_step_gen.sv
// Maps the current phase and step index to one bus transfer.
// Purely combinational; assumes idx stays within the phase's step range.
module ovw_step_gen
    import ovw_pkg::*;
#(
    parameter int AW = 16
) (
    input  phase_t        phase,
    input  logic [3:0]    idx,
    input  logic          stk,
    input  logic [7:0]    code,
    input  logic [31:0]   data,
    input  logic [31:0]   addr,
    input  logic [31:0]   cnt,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] fill_idx,
    input  logic [7:0]    fbyte,
    output logic          sp,
    output logic          we,
    output logic [AW-1:0] a,
    output logic [31:0]   wd
);
    // window offset scaled for the stacked arrangement, optionally mirrored
    function automatic logic [AW-1:0] win(input logic [7:0] off, input logic s, input logic m);
        logic [AW-1:0] b;
        b = AW'(off);
        if (s) b = b << 2;
        if (m) b = b + AW'(2);
        return b;
    endfunction

    logic        mirror;
    logic [3:0]  k;
    logic [7:0]  off;
    logic [15:0] val;

    // select the control register and value for CTRL steps
    always_comb begin
        mirror = stk && (idx >= 4'd6);
        k      = mirror ? idx - 4'd6 : idx;
        off    = OF_CODE;
        val    = {8'h00, code};
        case (k)
            4'd1: begin off = OF_DATA; val = mirror ? data[31:16] : data[15:0]; end
            4'd2: begin off = OF_ALO;  val = addr[15:0];  end
            4'd3: begin off = OF_AHI;  val = addr[31:16]; end
            4'd4: begin off = OF_CLO;  val = cnt[15:0];   end
            4'd5: begin off = OF_CHI;  val = cnt[31:16];  end
            default: ;
        endcase
    end

    // build the transfer for the current step
    always_comb begin
        sp = 1'b0;
        we = 1'b1;
        a  = '0;
        wd = '0;
        case (phase)
            PH_OPEN, PH_CLOSE: begin
                sp = 1'b1;
                if (idx == 4'd0) begin
                    a  = AW'(MR_CFG_ADR);
                    wd = (stk ? 32'h8000_0000 : 32'h0000_8000) | 32'h18;
                end else begin
                    a  = AW'(MR_DATA_ADR);
                    wd = (phase == PH_OPEN) ? 32'h1 : 32'h2;
                end
            end
            PH_CTRL: begin
                a  = win(off, stk, mirror);
                wd = {16'h0000, val};
            end
            PH_PTR: begin
                we = 1'b0;
                a  = win(OF_PTR, stk, 1'b0);
            end
            PH_FILL: begin
                a  = ptr + fill_idx;
                wd = {24'h0, fbyte};
            end
            PH_EXEC: begin
                a  = win(OF_EXEC, stk, idx[0]);
                wd = 32'h1;
            end
            PH_POLL: begin
                we = 1'b0;
                a  = win(OF_STAT, stk, idx[0]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ovw_cmd_seq.sv
// Overlay window command sequencer: opens the window, writes the command,
// optionally fills the program buffer, executes, polls status and closes.
// Assumes a bus partner that returns one single-cycle ack per request.
module ovw_cmd_seq
    import ovw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    cmd_code,
    input  logic [31:0]   cmd_data,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   cmd_count,
    input  logic          stacked,
    input  logic [15:0]   poll_limit,
    input  logic          fifo_push,
    input  logic [7:0]    fifo_byte,
    output logic          fifo_full,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_space,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);
    phase_t        phase;
    logic [3:0]    idx, last_idx;
    logic [7:0]    code_q;
    logic [31:0]   data_q, addr_q, cnt_q, fill_q;
    logic          stk_q, err_q;
    logic [15:0]   limit_q, poll_q, stlo_q;
    logic [AW-1:0] ptr_q;

    logic          f_empty, f_pop, step, bus_phase, status_ok, limit_hit;
    logic [7:0]    f_head;
    wire           unused_rdata_hi = ^mem_rdata[31:16];

    ovw_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_byte),
        .pop   (f_pop),
        .head  (f_head),
        .empty (f_empty),
        .full  (fifo_full)
    );

    ovw_step_gen #(.AW(AW)) u_step (
        .phase    (phase),
        .idx      (idx),
        .stk      (stk_q),
        .code     (code_q),
        .data     (data_q),
        .addr     (addr_q),
        .cnt      (cnt_q),
        .ptr      (ptr_q),
        .fill_idx (fill_q[AW-1:0]),
        .fbyte    (f_head),
        .sp       (mem_space),
        .we       (mem_we),
        .a        (mem_addr),
        .wd       (mem_wdata)
    );

    // last step index of each bus phase
    always_comb begin
        case (phase)
            PH_OPEN, PH_CLOSE: last_idx = 4'd1;
            PH_CTRL:           last_idx = stk_q ? 4'd11 : 4'd5;
            PH_EXEC, PH_POLL:  last_idx = stk_q ? 4'd1 : 4'd0;
            default:           last_idx = 4'd0;
        endcase
    end

    assign bus_phase = (phase != PH_IDLE) && (phase != PH_DONE);
    assign mem_req   = bus_phase && !((phase == PH_FILL) && f_empty);
    assign step      = mem_req && mem_ack;
    assign f_pop     = step && (phase == PH_FILL);
    assign status_ok = stk_q ? (stlo_q[7] && mem_rdata[7]) : mem_rdata[7];
    assign limit_hit = ({1'b0, poll_q} + 17'd1) >= {1'b0, limit_q};

    // phase sequencing, argument capture and poll bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            code_q  <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            stk_q   <= 1'b0;
            limit_q <= '0;
            poll_q  <= '0;
            stlo_q  <= '0;
            ptr_q   <= '0;
            fill_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase   <= PH_OPEN;
                    idx     <= '0;
                    code_q  <= cmd_code;
                    data_q  <= cmd_data;
                    addr_q  <= cmd_addr;
                    cnt_q   <= cmd_count;
                    stk_q   <= stacked;
                    limit_q <= poll_limit;
                    poll_q  <= '0;
                    fill_q  <= '0;
                    err_q   <= 1'b0;
                end
                PH_OPEN: if (step) begin
                    if (idx == last_idx) begin phase <= PH_CTRL; idx <= '0; end
                    else idx <= idx + 1'b1;
                end
                PH_CTRL: if (step) begin
                    if (idx == last_idx) begin
                        phase <= is_buffered(code_q) ? PH_PTR : PH_EXEC;
                        idx   <= '0;
                    end else idx <= idx + 1'b1;
                end
                PH_PTR: if (step) begin
                    ptr_q <= mem_rdata[AW-1:0];
                    phase <= (cnt_q == '0) ? PH_EXEC : PH_FILL;
                end
                PH_FILL: if (step) begin
                    fill_q <= fill_q + 32'd1;
                    if (fill_q + 32'd1 == cnt_q) phase <= PH_EXEC;
                end
                PH_EXEC: if (step) begin
                    if (idx == last_idx) begin phase <= PH_POLL; idx <= '0; end
                    else idx <= idx + 1'b1;
                end
                PH_POLL: if (step) begin
                    if (idx != last_idx) begin
                        stlo_q <= mem_rdata[15:0];
                        idx    <= idx + 1'b1;
                    end else begin
                        idx <= '0;
                        if (status_ok) begin
                            phase <= PH_CLOSE;
                        end else if (limit_hit) begin
                            phase <= PH_CLOSE;
                            err_q <= 1'b1;
                        end else begin
                            poll_q <= poll_q + 16'd1;
                        end
                    end
                end
                PH_CLOSE: if (step) begin
                    if (idx == last_idx) begin phase <= PH_DONE; idx <= '0; end
                    else idx <= idx + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_DONE);
    assign err  = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                   && $stable(mem_we) && $stable(mem_space))); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_space && mem_req && mem_ack)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(code_q) && $stable(addr_q) && $stable(cnt_q))); // R11
    AST_FILL_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL || phase == PH_PTR) |-> is_buffered(code_q)); // R6
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POLL) |-> (poll_q == 16'd0 || poll_q < limit_q)); // R9
endmodule

// File: tb/sim_ovw_cmd_seq.sv
// Bench: behavioural bus responder plus an expected-transfer queue built from
// the requirements; every acknowledged transfer and each done pulse is compared.
module sim_ovw_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [31:0] cmd_data = '0, cmd_addr = '0, cmd_count = '0;
    logic        stacked = 1'b0;
    logic [15:0] poll_limit = '0;
    logic        fifo_push = 1'b0;
    logic [7:0]  fifo_byte = '0;
    logic        fifo_full, busy, done, err;
    logic        mem_req, mem_space, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk; // 50 MHz

    ovw_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .stacked(stacked), .poll_limit(poll_limit), .fifo_push(fifo_push),
        .fifo_byte(fifo_byte), .fifo_full(fifo_full), .busy(busy), .done(done),
        .err(err), .mem_req(mem_req), .mem_space(mem_space), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic        sp;
        logic        we;
        logic [15:0] a;
        logic [31:0] d;
    } txn_t;

    txn_t  exp_q[$];
    string tag_q[$];
    logic [7:0] byte_q[$];
    int total = 0, bad = 0;
    int lo_round = 0, hi_round = 0, lo_reads = 0, hi_reads = 0;
    logic [15:0] stat_lo_a = 16'h66, stat_hi_a = 16'h68, ptr_a = 16'h08;
    localparam logic [15:0] PTR_VAL = 16'h0200;
    logic exp_err = 1'b0, want_done = 1'b0, completed = 1'b0;
    logic hold_pend = 1'b0;
    txn_t held;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic add(input logic sp, input logic we, input logic [15:0] a, input logic [31:0] d, input string tag);
        txn_t t;
        t.sp = sp; t.we = we; t.a = a; t.d = d;
        exp_q.push_back(t);
        tag_q.push_back(tag);
    endtask

    // bus responder: ack one cycle after a new request, status per round settings
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= 32'hDEAD_0000;
                if (!mem_space && !mem_we) begin
                    if (mem_addr == ptr_a) mem_rdata <= {16'h0, PTR_VAL};
                    else if (mem_addr == stat_lo_a) begin
                        mem_rdata <= 32'h0001_0100 | ((lo_reads >= lo_round) ? 32'h80 : 32'h0);
                        lo_reads++;
                    end else if (mem_addr == stat_hi_a) begin
                        mem_rdata <= 32'h0001_0100 | ((hi_reads >= hi_round) ? 32'h80 : 32'h0);
                        hi_reads++;
                    end
                end
            end
        end
    end

    // monitor: compare every acknowledged transfer, the done pulse and request stability
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done) begin
                chk(done === 1'b1, "R10", {63'd0, done}, 64'd1);
                chk(err === exp_err, exp_err ? "R9" : "R10", {63'd0, err}, {63'd0, exp_err});
                want_done = 1'b0;
                completed = 1'b1;
            end else if (done === 1'b1) begin
                chk(1'b0, "R10", 64'd1, 64'd0);
            end
            if (hold_pend) begin
                chk(mem_req && {mem_space, mem_we, mem_addr, mem_wdata} == held, "R12",
                    {mem_req, 14'd0, mem_space, mem_we, mem_addr, mem_wdata},
                    {1'b1, 14'd0, held});
            end
            hold_pend = mem_req && !mem_ack;
            held = {mem_space, mem_we, mem_addr, mem_wdata};
            if (mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", {15'd0, mem_space, mem_we, mem_addr, mem_wdata}, 64'd0);
                end else begin
                    txn_t e;
                    string tg;
                    logic ok;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    ok = (mem_space == e.sp) && (mem_we == e.we) && (mem_addr == e.a)
                         && (!e.we || mem_wdata == e.d);
                    chk(ok, tg, {15'd0, mem_space, mem_we, mem_addr, mem_wdata},
                        {15'd0, e.sp, e.we, e.a, e.d});
                    if (exp_q.size() == 0) want_done = 1'b1;
                end
            end
        end
    end

    // build the expected transfer list from the requirements
    task automatic build(input logic [7:0] code, input logic [31:0] data, input logic [31:0] addr,
                         input logic [31:0] cnt, input logic stk, input int limit);
        int sc, lim, r;
        logic rdy, buff;
        logic [7:0]  offs[6];
        logic [15:0] vals[6];
        sc = stk ? 4 : 1;
        buff = (code == 8'hE9) || (code == 8'hEA);
        offs = '{8'h40, 8'h42, 8'h44, 8'h45, 8'h48, 8'h49};
        vals = '{{8'h0, code}, data[15:0], addr[15:0], addr[31:16], cnt[15:0], cnt[31:16]};
        stat_lo_a = 16'(8'h66 * sc);
        stat_hi_a = stk ? 16'(8'h66 * sc + 2) : 16'hFFFF;
        ptr_a     = 16'(8'h08 * sc);
        add(1, 1, 16'h50, stk ? 32'h8000_0018 : 32'h0000_8018, "R2");
        add(1, 1, 16'h40, 32'h1, "R2");
        for (int i = 0; i < 6; i++) add(0, 1, 16'(offs[i] * sc), {16'h0, vals[i]}, "R3");
        if (stk) begin
            for (int i = 0; i < 6; i++)
                add(0, 1, 16'(offs[i] * sc + 2), {16'h0, (i == 1) ? data[31:16] : vals[i]}, "R4");
        end
        if (buff) begin
            add(0, 0, ptr_a, 32'h0, "R5");
            for (int i = 0; i < int'(cnt); i++) add(0, 1, PTR_VAL + 16'(i), {24'h0, byte_q.pop_front()}, "R5");
        end
        add(0, 1, 16'(8'h60 * sc), 32'h1, buff ? "R7" : "R6");
        if (stk) add(0, 1, 16'(8'h60 * sc + 2), 32'h1, "R4");
        lim = (limit == 0) ? 1 : limit;
        r = 0;
        rdy = 1'b0;
        while (1) begin
            add(0, 0, stat_lo_a, 32'h0, "R8");
            if (stk) add(0, 0, stat_hi_a, 32'h0, "R4");
            rdy = stk ? (r >= lo_round && r >= hi_round) : (r >= lo_round);
            r++;
            if (rdy || r >= lim) break;
        end
        exp_err = !rdy;
        add(1, 1, 16'h50, stk ? 32'h8000_0018 : 32'h0000_8018, "R10");
        add(1, 1, 16'h40, 32'h2, "R10");
    endtask

    task automatic push_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fifo_push = 1'b1;
            fifo_byte = 8'(seed + i * 37);
            byte_q.push_back(8'(seed + i * 37));
        end
        @(negedge clk);
        fifo_push = 1'b0;
    endtask

    task automatic issue(input logic [7:0] code, input logic [31:0] data, input logic [31:0] addr,
                         input logic [31:0] cnt, input logic stk, input int limit, input int lo, input int hi);
        @(negedge clk);
        lo_round = lo; hi_round = hi; lo_reads = 0; hi_reads = 0;
        completed = 1'b0;
        build(code, data, addr, cnt, stk, limit);
        cmd_code = code; cmd_data = data; cmd_addr = addr; cmd_count = cnt;
        stacked = stk; poll_limit = 16'(limit);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!completed && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(completed && exp_q.size() == 0, tag, {63'd0, completed}, 64'd1);
        repeat (3) @(negedge clk);
        exp_q.delete();
        tag_q.delete();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // main sequence
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err, mem_req, fifo_full} == 5'b0, "R1",
            {59'd0, busy, done, err, mem_req, fifo_full}, 64'd0);

        // R6: erase, ready at first poll
        issue(8'h20, 32'h0, 32'h1234_5678, 32'h1234_5678, 1'b0, 8, 0, 0);
        wait_done("R6");

        // R11: word overwrite, ready on third poll, second start while busy
        issue(8'h42, 32'hBEEF_1234, 32'h0000_ABCD, 32'h0, 1'b0, 8, 2, 0);
        repeat (6) @(negedge clk);
        cmd_code = 8'h62; cmd_addr = 32'h5555_5555; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R11");
        repeat (20) @(negedge clk);
        chk(!busy && !mem_req, "R11", {62'd0, busy, mem_req}, 64'd0);

        // R5: buffered program, five bytes
        push_bytes(5, 8'h11);
        issue(8'hE9, 32'h0, 32'h0004_0000, 32'd5, 1'b0, 8, 1, 0);
        wait_done("R5");

        // R4: stacked lock, halves ready at different rounds
        issue(8'h61, 32'hCAFE_F00D, 32'h0002_0000, 32'h0002_0000, 1'b1, 10, 1, 3);
        wait_done("R4");

        // R4/R5: stacked buffered overwrite, three bytes
        push_bytes(3, 8'hA0);
        issue(8'hEA, 32'h0, 32'h0000_0100, 32'd3, 1'b1, 10, 0, 0);
        wait_done("R5");

        // R9: timeout after four rounds, single
        issue(8'h41, 32'h0000_7777, 32'h10, 32'h0, 1'b0, 4, 1000, 0);
        wait_done("R9");

        // R9: stacked unlock, limit 0 acts as one round, high half never ready
        issue(8'h62, 32'h0, 32'h0006_0000, 32'h0006_0000, 1'b1, 0, 0, 1000);
        wait_done("R9");

        // R8: single block erase with slow ready
        issue(8'h20, 32'h0, 32'h0008_0000, 32'h0008_0000, 1'b0, 20, 7, 0);
        wait_done("R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule